// File: doc/BRIEF.md
# ModR/M and SIB Effective Offset Generator

This block works out the effective offset of a single memory operand from an x86-style addressing byte, an optional scale-index-base byte and an optional displacement. The bytes that follow an opcode arrive one per beat on a valid/ready byte stream. The eight general-purpose registers come in as one parallel snapshot, and the snapshot must stay stable from the addressing byte until the result is acknowledged. A short control sequence consumes exactly as many bytes as the encoding calls for. It then presents the offset, the number of bytes it consumed, an invalid-encoding flag and a protection-fault flag. The result is held until the caller acknowledges it.

The caller uses the byte count to advance its instruction pointer past the operand. It uses the two flags to raise the matching exceptions. Segment translation, memory access and opcode decoding are left to the surrounding logic. An optional register stage after the three-input adder, chosen by a parameter, takes the sum off the path to the result at the cost of one cycle.

Top module: `ea_offset_gen`

## Requirements
- R1: The addressing byte is read as mod = bits 7:6 and rm = bits 2:0. A second (SIB) byte is taken only when rm = 4 and mod ≠ 3. That byte is read as scale = bits 7:6, index = bits 5:3 and base = bits 2:0.
- R2: Register codes 0..7 select, in order, the registers eax, ecx, edx, ebx, esp, ebp, esi and edi, which occupy slices 0..7 of the snapshot. Without a SIB byte, mod 0 gives the register rm itself. mod 1 adds a sign-extended 8-bit displacement to it. mod 2 adds a 32-bit displacement to it, and that displacement arrives least significant byte first.
- R3: With a SIB byte, the offset is base + (index register << scale) + displacement, with the sum wrapping at 32 bits. An index code of 4 contributes no index term.
- R4: An index code of 4 together with a nonzero scale sets the invalid flag, and the offset is still computed without an index term.
- R5: With a SIB byte, mod 0 and base code 5, no base register is added and a 32-bit displacement follows.
- R6: Without a SIB byte, mod 0 and rm 5 give a bare 32-bit displacement as the offset, with no register added.
- R7: mod 3 (register form) sets the invalid flag, consumes only the addressing byte and reports an offset of 0.
- R8: The protection-fault flag is set exactly when flat mode is selected, bit 4 of the addressing byte (the write bit) is 1 and the code-segment override is active. All three are sampled with the addressing byte.
- R9: The reported length is 1 + (1 if a SIB byte was taken) + the number of displacement bytes (0, 1 or 4).
- R10: After reset, and after each acknowledged result, the block is ready for a new addressing byte with no result showing. While a result is showing it accepts no bytes, and the result stays unchanged until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Stream byte offered |
| in_data | input | 8 | Stream byte |
| in_ready | output | 1 | Block accepts a byte this cycle |
| gpr_flat | input | 256 | Register snapshot, register n in bits 32n+31:32n |
| flat_mode | input | 1 | Flat 32-bit addressing in force |
| cs_override | input | 1 | Operand uses a code-segment override |
| res_valid | output | 1 | Result is presented |
| res_ack | input | 1 | Caller takes the result |
| res_offset | output | 32 | Effective offset |
| res_len | output | 3 | Bytes consumed after the opcode (1 to 6) |
| res_invalid | output | 1 | Illegal encoding |
| res_prot_fault | output | 1 | Write through code segment in flat mode |

## Verification
The bench builds the block with a 32-bit address width and the registered-sum option switched on. With that option the result appears one cycle after the last byte, so the hold-until-acknowledge check also covers the stage that captures the adder output. Random gaps between stream beats and random acknowledge delays exercise stalls in every collection phase. Random register contents put negative 8-bit displacements and scaled indices that wrap at 32 bits within reach.

// File: rtl/ea_offset_pkg.sv
package ea_offset_pkg;

   localparam int unsigned GPR_COUNT = 8;
   localparam logic [1:0]  MOD_REGFORM = 2'd3;
   localparam logic [2:0]  CODE_SIB    = 3'd4;
   localparam logic [2:0]  CODE_NOIDX  = 3'd4;
   localparam logic [2:0]  CODE_ABS    = 3'd5;

   typedef enum logic [2:0] {
      ST_MODRM,
      ST_SIB,
      ST_DISP,
      ST_CALC,
      ST_DONE
   } ea_state_e;

   typedef struct packed {
      logic [1:0] mode;
      logic [2:0] rm;
      logic       has_sib;
      logic [1:0] scale;
      logic [2:0] index;
      logic [2:0] base;
   } ea_fields_t;

   // displacement bytes implied by the addressing byte alone (SIB case decided later)
   function automatic int unsigned disp_after_modrm(input logic [7:0] b, input int unsigned wide);
      logic [1:0] m;
      logic [2:0] r;
      m = b[7:6];
      r = b[2:0];
      if (m == MOD_REGFORM)  return 0;
      if (r == CODE_SIB)     return 0;
      if (m == 2'd1)         return 1;
      if (m == 2'd2)         return wide;
      if (r == CODE_ABS)     return wide;
      return 0;
   endfunction

   function automatic int unsigned disp_after_sib(input logic [1:0] m, input logic [7:0] s,
                                                  input int unsigned wide);
      if (m == 2'd1)             return 1;
      if (m == 2'd2)             return wide;
      if (s[2:0] == CODE_ABS)    return wide;
      return 0;
   endfunction

endpackage

// File: rtl/ea_offset_ctrl.sv
module ea_offset_ctrl
   import ea_offset_pkg::*;
#(
   parameter int unsigned ADDR_W   = 32,
   parameter int unsigned SUM_PIPE = 1,
   localparam int unsigned DISP_BYTES = ADDR_W / 8,
   localparam int unsigned CNT_W      = $clog2(DISP_BYTES + 1),
   localparam int unsigned LEN_W      = $clog2(DISP_BYTES + 3)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [7:0]       in_data,
   output logic             in_ready,
   input  logic             flat_mode,
   input  logic             cs_override,
   input  logic             res_ack,
   output ea_fields_t       fields_o,
   output logic [CNT_W-1:0] disp_len_o,
   output logic             disp_clr_o,
   output logic             disp_wr_o,
   output logic [CNT_W-1:0] disp_idx_o,
   output logic             calc_o,
   output logic             done_o,
   output logic [LEN_W-1:0] len_o,
   output logic             fault_o
);

   ea_state_e        st_q, st_nx, fin_st;
   ea_fields_t       fld_q;
   logic [CNT_W-1:0] need_q, cnt_q;
   logic [CNT_W-1:0] need_m, need_s;
   logic             fault_q;
   logic             take;
   logic             unused_opbits;

   assign unused_opbits = ^{in_data[5], in_data[3]};

   assign fin_st   = (SUM_PIPE != 0) ? ST_CALC : ST_DONE;
   assign in_ready = (st_q == ST_MODRM) || (st_q == ST_SIB) || (st_q == ST_DISP);
   assign take     = in_valid && in_ready;
   assign need_m   = CNT_W'(disp_after_modrm(in_data, DISP_BYTES));
   assign need_s   = CNT_W'(disp_after_sib(fld_q.mode, in_data, DISP_BYTES));

   always_comb begin
      st_nx = st_q;
      unique case (st_q)
         ST_MODRM: if (take) begin
            if (in_data[7:6] == MOD_REGFORM)  st_nx = fin_st;
            else if (in_data[2:0] == CODE_SIB) st_nx = ST_SIB;
            else if (need_m != '0)             st_nx = ST_DISP;
            else                               st_nx = fin_st;
         end
         ST_SIB: if (take) begin
            if (need_s != '0) st_nx = ST_DISP;
            else              st_nx = fin_st;
         end
         ST_DISP: if (take && (cnt_q == need_q - CNT_W'(1))) st_nx = fin_st;
         ST_CALC: st_nx = ST_DONE;
         ST_DONE: if (res_ack) st_nx = ST_MODRM;
         default: st_nx = ST_MODRM;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q    <= ST_MODRM;
         fld_q   <= '0;
         need_q  <= '0;
         cnt_q   <= '0;
         fault_q <= 1'b0;
      end else begin
         st_q <= st_nx;
         if (take) begin
            unique case (st_q)
               ST_MODRM: begin
                  fld_q.mode    <= in_data[7:6];
                  fld_q.rm      <= in_data[2:0];
                  fld_q.has_sib <= (in_data[2:0] == CODE_SIB) && (in_data[7:6] != MOD_REGFORM);
                  fld_q.scale   <= '0;
                  fld_q.index   <= CODE_NOIDX;
                  fld_q.base    <= '0;
                  need_q        <= need_m;
                  cnt_q         <= '0;
                  fault_q       <= flat_mode && in_data[4] && cs_override;
               end
               ST_SIB: begin
                  fld_q.scale <= in_data[7:6];
                  fld_q.index <= in_data[5:3];
                  fld_q.base  <= in_data[2:0];
                  need_q      <= need_s;
               end
               ST_DISP: cnt_q <= cnt_q + CNT_W'(1);
               default: ;
            endcase
         end
      end
   end

   assign fields_o   = fld_q;
   assign disp_len_o = need_q;
   assign disp_clr_o = take && (st_q == ST_MODRM);
   assign disp_wr_o  = take && (st_q == ST_DISP);
   assign disp_idx_o = cnt_q;
   assign calc_o     = (st_q == ST_CALC);
   assign done_o     = (st_q == ST_DONE);
   assign fault_o    = fault_q;
   assign len_o      = LEN_W'(1) + LEN_W'(fld_q.has_sib) + LEN_W'(need_q);

   // R7: a register-form byte ends the collection at once
   p_regform_stops_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (take && (st_q == ST_MODRM) && (in_data[7:6] == MOD_REGFORM)) |=> !in_ready);

   // R1: a SIB byte is awaited right after rm=4 with a memory mod
   p_sib_awaited_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (take && (st_q == ST_MODRM) && (in_data[2:0] == CODE_SIB) && (in_data[7:6] != MOD_REGFORM))
      |=> in_ready);

   // R10: acknowledging a result reopens the byte stream
   p_ack_reopens_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && res_ack) |=> (in_ready && !done_o));

endmodule

// File: rtl/ea_offset_disp.sv
module ea_offset_disp #(
   parameter int unsigned ADDR_W = 32,
   localparam int unsigned DISP_BYTES = ADDR_W / 8,
   localparam int unsigned CNT_W      = $clog2(DISP_BYTES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              wr,
   input  logic [CNT_W-1:0]  idx,
   input  logic [7:0]        byte_in,
   output logic [ADDR_W-1:0] disp_raw
);

   for (genvar g = 0; g < DISP_BYTES; g++) begin : g_lane
      logic [7:0] lane_q;
      always_ff @(posedge clk) begin
         if (!rst_n || clr)                     lane_q <= '0;
         else if (wr && (idx == CNT_W'(g)))     lane_q <= byte_in;
      end
      assign disp_raw[g*8 +: 8] = lane_q;
   end

   // R2: a displacement write never targets a lane past the top byte
   p_lane_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
      wr |-> (idx < CNT_W'(DISP_BYTES)));

endmodule

// File: rtl/ea_offset_sum.sv
module ea_offset_sum
   import ea_offset_pkg::*;
#(
   parameter int unsigned ADDR_W = 32,
   localparam int unsigned DISP_BYTES = ADDR_W / 8,
   localparam int unsigned CNT_W      = $clog2(DISP_BYTES + 1)
) (
   input  ea_fields_t                  fields,
   input  logic [GPR_COUNT*ADDR_W-1:0] gpr_flat,
   input  logic [ADDR_W-1:0]           disp_raw,
   input  logic [CNT_W-1:0]            disp_len,
   output logic [ADDR_W-1:0]           offset,
   output logic                        invalid
);

   logic [ADDR_W-1:0] gpr [GPR_COUNT];
   logic [ADDR_W-1:0] base_term, idx_term, disp_term;
   logic [2:0]        base_sel;
   logic              base_on, idx_on, regform;

   for (genvar g = 0; g < GPR_COUNT; g++) begin : g_unpack
      assign gpr[g] = gpr_flat[g*ADDR_W +: ADDR_W];
   end

   assign regform  = (fields.mode == MOD_REGFORM);
   assign base_sel = fields.has_sib ? fields.base : fields.rm;
   assign base_on  = fields.has_sib ? !((fields.mode == 2'd0) && (fields.base == CODE_ABS))
                                    : !((fields.mode == 2'd0) && (fields.rm == CODE_ABS));
   assign idx_on   = fields.has_sib && (fields.index != CODE_NOIDX);

   assign base_term = base_on ? gpr[base_sel] : '0;
   assign idx_term  = idx_on ? (gpr[fields.index] << fields.scale) : '0;
   assign disp_term = (disp_len == CNT_W'(1)) ? {{(ADDR_W-8){disp_raw[7]}}, disp_raw[7:0]}
                                              : disp_raw;

   assign offset  = regform ? '0 : (base_term + idx_term + disp_term);
   assign invalid = regform ||
                    (fields.has_sib && (fields.index == CODE_NOIDX) && (fields.scale != 2'd0));

endmodule

// File: rtl/ea_offset_gen.sv
module ea_offset_gen
   import ea_offset_pkg::*;
#(
   parameter int unsigned ADDR_W   = 32,
   parameter int unsigned SUM_PIPE = 0
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          in_valid,
   input  logic [7:0]                    in_data,
   output logic                          in_ready,
   input  logic [8*ADDR_W-1:0]           gpr_flat,
   input  logic                          flat_mode,
   input  logic                          cs_override,
   output logic                          res_valid,
   input  logic                          res_ack,
   output logic [ADDR_W-1:0]             res_offset,
   output logic [$clog2(ADDR_W/8+3)-1:0] res_len,
   output logic                          res_invalid,
   output logic                          res_prot_fault
);

   localparam int unsigned DISP_BYTES = ADDR_W / 8;
   localparam int unsigned CNT_W      = $clog2(DISP_BYTES + 1);
   localparam int unsigned LEN_W      = $clog2(DISP_BYTES + 3);

   if ((ADDR_W % 8) != 0 || ADDR_W < 16) begin : g_bad_width
      $error("ea_offset_gen: ADDR_W must be a multiple of 8 and at least 16");
   end
   if (SUM_PIPE > 1) begin : g_bad_pipe
      $error("ea_offset_gen: SUM_PIPE must be 0 or 1");
   end

   ea_fields_t        fields;
   logic [CNT_W-1:0]  disp_len, disp_idx;
   logic              disp_clr, disp_wr, calc, done, fault;
   logic [LEN_W-1:0]  len;
   logic [ADDR_W-1:0] disp_raw, sum_off;
   logic              sum_inv;

   ea_offset_ctrl #(.ADDR_W(ADDR_W), .SUM_PIPE(SUM_PIPE)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
      .flat_mode(flat_mode), .cs_override(cs_override), .res_ack(res_ack),
      .fields_o(fields), .disp_len_o(disp_len), .disp_clr_o(disp_clr), .disp_wr_o(disp_wr),
      .disp_idx_o(disp_idx), .calc_o(calc), .done_o(done), .len_o(len), .fault_o(fault)
   );

   ea_offset_disp #(.ADDR_W(ADDR_W)) u_disp (
      .clk(clk), .rst_n(rst_n), .clr(disp_clr), .wr(disp_wr), .idx(disp_idx),
      .byte_in(in_data), .disp_raw(disp_raw)
   );

   ea_offset_sum #(.ADDR_W(ADDR_W)) u_sum (
      .fields(fields), .gpr_flat(gpr_flat), .disp_raw(disp_raw), .disp_len(disp_len),
      .offset(sum_off), .invalid(sum_inv)
   );

   if (SUM_PIPE != 0) begin : g_pipe
      logic [ADDR_W-1:0] off_q;
      logic              inv_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            off_q <= '0;
            inv_q <= 1'b0;
         end else if (calc) begin
            off_q <= sum_off;
            inv_q <= sum_inv;
         end
      end
      assign res_offset  = off_q;
      assign res_invalid = inv_q;
   end else begin : g_comb
      logic unused_calc;
      assign unused_calc = calc;
      assign res_offset  = sum_off;
      assign res_invalid = sum_inv;
   end

   assign res_valid      = done;
   assign res_len        = len;
   assign res_prot_fault = fault;

   // R10: a presented result holds until acknowledged
   p_result_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && !res_ack) |=> (res_valid && $stable(res_offset) && $stable(res_len)
                                   && $stable(res_invalid) && $stable(res_prot_fault)));

   // R9: the byte count stays within one to two-plus-displacement bytes
   p_len_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> ((res_len >= LEN_W'(1)) && (res_len <= LEN_W'(DISP_BYTES + 2))));

endmodule

// File: tb/ea_offset_gen_test.sv
module ea_offset_gen_test;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic [7:0]    in_data = '0;
   logic          in_ready;
   logic [255:0]  gpr_flat;
   logic          flat_mode = 1'b0;
   logic          cs_override = 1'b0;
   logic          res_valid;
   logic          res_ack = 1'b0;
   logic [31:0]   res_offset;
   logic [2:0]    res_len;
   logic          res_invalid;
   logic          res_prot_fault;

   logic [31:0]   rf [8];
   int            checks = 0;
   int            errs = 0;
   int            cyc = 0;
   bit            wd_hit = 1'b0;

   always #5 clk = ~clk;

   always_comb for (int i = 0; i < 8; i++) gpr_flat[i*32 +: 32] = rf[i];

   ea_offset_gen #(.ADDR_W(32), .SUM_PIPE(1)) uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
      .gpr_flat(gpr_flat), .flat_mode(flat_mode), .cs_override(cs_override),
      .res_valid(res_valid), .res_ack(res_ack), .res_offset(res_offset), .res_len(res_len),
      .res_invalid(res_invalid), .res_prot_fault(res_prot_fault)
   );

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000 && !wd_hit) begin
         wd_hit = 1'b1;
         checks++; errs++;
         $display("FAIL watchdog: got %0d cycles expected completion", cyc);
         finish_run();
      end
   end

   task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s: got %h expected %h", rq, act, exp);
      end
   endtask

   function automatic void ref_ea(input logic [7:0] m, input logic [7:0] s, input logic [31:0] d,
                                  input logic fl, input logic cs,
                                  output logic [31:0] off, output int len, output logic inv,
                                  output logic flt, output int nd, output logic sibp);
      logic [1:0]  md;
      logic [2:0]  r;
      logic [31:0] b, ix, dv;
      md   = m[7:6];
      r    = m[2:0];
      sibp = (r == 3'd4) && (md != 2'd3);
      flt  = fl && m[4] && cs;
      if (md == 2'd3) begin
         off = 0; len = 1; inv = 1'b1; nd = 0;
         return;
      end
      if (sibp) begin
         nd  = (md == 2'd1) ? 1 : (md == 2'd2) ? 4 : (s[2:0] == 3'd5) ? 4 : 0;
         b   = ((md == 2'd0) && (s[2:0] == 3'd5)) ? 32'd0 : rf[s[2:0]];
         ix  = (s[5:3] == 3'd4) ? 32'd0 : (rf[s[5:3]] << s[7:6]);
         inv = (s[5:3] == 3'd4) && (s[7:6] != 2'd0);
      end else begin
         nd  = (md == 2'd1) ? 1 : (md == 2'd2) ? 4 : (r == 3'd5) ? 4 : 0;
         b   = ((md == 2'd0) && (r == 3'd5)) ? 32'd0 : rf[r];
         ix  = 32'd0;
         inv = 1'b0;
      end
      dv  = (nd == 1) ? {{24{d[7]}}, d[7:0]} : (nd == 4) ? d : 32'd0;
      off = b + ix + dv;
      len = 1 + (sibp ? 1 : 0) + nd;
   endfunction

   task automatic push(input logic [7:0] b);
      int gap;
      gap = $urandom_range(0, 1);
      for (int k = 0; k < gap; k++) begin
         @(negedge clk); in_valid = 1'b0;
      end
      @(negedge clk); in_valid = 1'b1; in_data = b;
      while (!in_ready) @(negedge clk);
      @(posedge clk); #1;
      in_valid = 1'b0;
   endtask

   task automatic op(input string rq, input logic [7:0] m, input logic [7:0] s,
                     input logic [31:0] d, input logic fl, input logic cs);
      logic [31:0] e_off, h_off;
      int          e_len, nd, waitc, hold;
      logic        e_inv, e_flt, sibp;
      ref_ea(m, s, d, fl, cs, e_off, e_len, e_inv, e_flt, nd, sibp);
      flat_mode = fl; cs_override = cs;
      push(m);
      if (sibp) push(s);
      for (int k = 0; k < nd; k++) push(d[k*8 +: 8]);
      waitc = 0;
      @(negedge clk);
      while (!res_valid && waitc < 10) begin @(negedge clk); waitc++; end
      chk({rq, " R10 result shown"}, {31'd0, res_valid}, 32'd1);
      chk({rq, " offset"}, res_offset, e_off);
      chk("R9 length", {29'd0, res_len}, e_len[31:0]);
      chk({rq, " R4/R7 invalid"}, {31'd0, res_invalid}, {31'd0, e_inv});
      chk("R8 fault", {31'd0, res_prot_fault}, {31'd0, e_flt});
      h_off = res_offset;
      hold = $urandom_range(0, 2);
      for (int k = 0; k < hold; k++) begin
         in_valid = 1'b1; in_data = 8'h00;
         @(negedge clk);
         chk("R10 no byte taken while showing", {31'd0, in_ready}, 32'd0);
         chk("R10 offset held", res_offset, h_off);
      end
      in_valid = 1'b0;
      res_ack = 1'b1;
      @(negedge clk);
      res_ack = 1'b0;
      chk("R10 ready after ack", {30'd0, in_ready, res_valid}, 32'd2);
   endtask

   initial begin
      void'($urandom(32'h0eaf_1234));
      for (int i = 0; i < 8; i++) rf[i] = 32'h1000_0000 * (i + 1) + 32'h11 * i;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R10 reset ready", {31'd0, in_ready}, 32'd1);
      chk("R10 reset no result", {31'd0, res_valid}, 32'd0);

      op("R2 reg indirect ebx", 8'b00_000_011, 8'h00, 32'h0, 1'b0, 1'b0);
      op("R2 mod1 negative disp", 8'b01_000_110, 8'h00, 32'h0000_00F0, 1'b0, 1'b0);
      op("R2 mod2 disp32", 8'b10_000_001, 8'h00, 32'h1234_5678, 1'b0, 1'b0);
      op("R6 absolute", 8'b00_000_101, 8'h00, 32'hCAFE_BABE, 1'b0, 1'b0);
      op("R3 scaled index", 8'b10_000_100, 8'b11_001_010, 32'h0000_0040, 1'b0, 1'b0);
      op("R3 no index", 8'b01_000_100, 8'b00_100_000, 32'h0000_0007, 1'b0, 1'b0);
      op("R4 scale without index", 8'b00_000_100, 8'b10_100_011, 32'h0, 1'b0, 1'b0);
      op("R5 no base disp32", 8'b00_000_100, 8'b01_110_101, 32'h0BAD_F00D, 1'b0, 1'b0);
      op("R1 esp base", 8'b00_000_100, 8'b00_100_100, 32'h0, 1'b0, 1'b0);
      op("R7 register form", 8'b11_000_010, 8'h00, 32'h0, 1'b0, 1'b0);
      op("R8 write via cs flat", 8'b00_010_011, 8'h00, 32'h0, 1'b1, 1'b1);
      op("R8 read via cs flat", 8'b00_001_011, 8'h00, 32'h0, 1'b1, 1'b1);
      op("R8 write via cs segmented", 8'b00_010_011, 8'h00, 32'h0, 1'b0, 1'b1);

      for (int n = 0; n < 300; n++) begin
         for (int i = 0; i < 8; i++) rf[i] = $urandom;
         op("R3 random", 8'($urandom), 8'($urandom), $urandom,
            1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
      end

      finish_run();
   end

endmodule